// File: doc/BRIEF.md
# Page-Table IO Address Translator

This block sits between a PCI-side DMA requester and system memory. It maps each 4 KiB-page IO address onto a system address using a flat, single-level page directory that lives in system memory. Three 64-bit configuration registers set up the translation:

- a window base, whose bit 0 turns translation on;
- a window mask;
- the directory base.

For each request the block first decides whether the address falls inside the enabled window. Addresses outside the window, or any address while translation is off, come straight back unchanged one cycle after acceptance and cause no memory traffic. An address inside the window needs its directory entry. The block reads that one 64-bit entry through its memory read master. It then answers with the translated address, or with a fault if the entry is not marked valid.

Only one translation is in flight at a time. The request port stays stalled from acceptance until the entry read completes. Software loads the configuration registers through a simple write port that takes full 64-bit writes or 32-bit half writes.

Top module: `iot_translator`

## Requirements
- R1: After synchronous reset, the three configuration registers are zero, `req_ready` is 1, and `rsp_valid` and `mem_rd_valid` are 0. Until the registers are written, every request passes through unchanged.
- R2: While bit 0 of the window base is 0, an accepted request gets `rsp_valid`=1 in the next cycle, with `rsp_addr` equal to the request address and `rsp_fault`=0. No memory read is issued.
- R3: With translation enabled, a request whose (address AND mask) differs from the window base with bit 0 cleared passes through exactly as in R2.
- R4: A request inside the enabled window raises `mem_rd_valid` in the next cycle. `mem_rd_addr` is the directory base plus (address >> 12) × 8. Both stay constant until the cycle in which `mem_rd_ack` is sampled high.
- R5: When the returned entry has bit 63 set, `rsp_valid` rises one cycle after the acknowledge. `rsp_addr` is bits 62..12 of the entry, with bit 63 forced to 0, joined to bits 11..0 of the request address. `rsp_fault` is 0.
- R6: When the returned entry has bit 63 clear, the response carries `rsp_fault`=1 and `rsp_addr`=0.
- R7: `req_ready` is 0 from the cycle after a translating request is accepted until the response cycle, so at most one entry read is outstanding.
- R8: Register select codes are 0 for the window base, 1 for the mask, 2 for the directory base; code 3 writes nothing. With `reg_half`=0 all 64 bits are written. With `reg_half`=1, `wdata[31:0]` goes to bits 63..32 when `reg_hi`=1 and to bits 31..0 when `reg_hi`=0, and the other half is kept.
- R9: A register write in the same cycle that a request is accepted affects only later requests. A directory-base write during an entry read does not move the outstanding read.
- R10: Each accepted request produces exactly one single-cycle `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Configuration write strobe |
| reg_sel | input | 2 | Register select: 0 base, 1 mask, 2 directory base, 3 none |
| reg_half | input | 1 | 1 = 32-bit half write |
| reg_hi | input | 1 | Half write goes to the upper half |
| reg_wdata | input | 64 | Write data |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 64 | IO address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_fault | output | 1 | Entry was not valid |
| mem_rd_valid | output | 1 | Entry read request, held until ack |
| mem_rd_addr | output | 64 | Byte address of the directory entry |
| mem_rd_ack | input | 1 | Entry data is present this cycle |
| mem_rd_data | input | 64 | Entry, least significant byte in bits 7..0 |

## Verification
Two functions can land in the same cycle: a configuration write and the acceptance of a request that the write would reclassify. The bench drives a base write that disables translation on the very edge that accepts an in-window request. It expects the entry read to go out anyway, because the decision must use the old settings. It then writes the directory base while that read is pending and expects `mem_rd_addr` not to move. Finally it expects the next request to pass straight through under the new settings.

// File: rtl/iot_pkg.sv
package iot_pkg;
  localparam int NUM_REGS   = 3;
  localparam int PAGE_SHIFT = 12;
  localparam int ENTRY_LOG2 = 3;
  localparam logic [1:0] SEL_BASE  = 2'd0;
  localparam logic [1:0] SEL_MASK  = 2'd1;
  localparam logic [1:0] SEL_DBASE = 2'd2;

  typedef enum logic [0:0] {
    WK_IDLE  = 1'b0,
    WK_FETCH = 1'b1
  } walk_state_t;
endpackage

// File: rtl/iot_cfg_regs.sv
module iot_cfg_regs
  import iot_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic          half,
  input  logic          hi,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] mask_q,
  output logic [AW-1:0] dbase_q
);
  localparam int HW = AW / 2;

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [AW-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= '0;
        end else if (we && (sel == g[1:0])) begin
          if (!half)   q           <= wdata;
          else if (hi) q[AW-1:HW]  <= wdata[HW-1:0];
          else         q[HW-1:0]   <= wdata[HW-1:0];
        end
      end
    end
  endgenerate

  assign base_q  = g_reg[0].q;
  assign mask_q  = g_reg[1].q;
  assign dbase_q = g_reg[2].q;

  // R8: an upper-half write leaves the lower half of the base untouched
  p_half_keep_low_r8: assert property (@(posedge clk) disable iff (rst)
    (we && half && hi && sel == SEL_BASE) |=> base_q[HW-1:0] == $past(base_q[HW-1:0]));

  // R8: select code 3 changes no register
  p_sel3_noop_r8: assert property (@(posedge clk) disable iff (rst)
    (we && sel == 2'd3) |=> ($stable(base_q) && $stable(mask_q) && $stable(dbase_q)));
endmodule

// File: rtl/iot_window.sv
module iot_window
  import iot_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] mask,
  input  logic [AW-1:0] dbase,
  output logic          hit,
  output logic [AW-1:0] entry_addr
);
  logic [AW-1:0] cmp_base;
  logic [AW-1:0] page_idx;

  always_comb begin
    cmp_base   = {base[AW-1:1], 1'b0};
    hit        = base[0] && ((addr & mask) == cmp_base);
    page_idx   = addr >> PAGE_SHIFT;
    entry_addr = dbase + (page_idx << ENTRY_LOG2);
  end
endmodule

// File: rtl/iot_walker.sv
module iot_walker
  import iot_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          hit,
  input  logic [AW-1:0] entry_addr,
  output logic          req_ready,
  output logic          mem_rd_valid,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_ack,
  input  logic [AW-1:0] mem_rd_data,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_addr,
  output logic          rsp_fault
);
  localparam int VBIT = AW - 1;

  walk_state_t          state;
  logic [PAGE_SHIFT-1:0] offset_q;

  assign req_ready = (state == WK_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= WK_IDLE;
      offset_q     <= '0;
      mem_rd_valid <= 1'b0;
      mem_rd_addr  <= '0;
      rsp_valid    <= 1'b0;
      rsp_addr     <= '0;
      rsp_fault    <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        WK_IDLE: begin
          if (req_valid) begin
            if (hit) begin
              state        <= WK_FETCH;
              mem_rd_valid <= 1'b1;
              mem_rd_addr  <= entry_addr;
              offset_q     <= req_addr[PAGE_SHIFT-1:0];
            end else begin
              rsp_valid <= 1'b1;
              rsp_addr  <= req_addr;
              rsp_fault <= 1'b0;
            end
          end
        end
        WK_FETCH: begin
          if (mem_rd_ack) begin
            state        <= WK_IDLE;
            mem_rd_valid <= 1'b0;
            rsp_valid    <= 1'b1;
            if (mem_rd_data[VBIT]) begin
              rsp_addr  <= {1'b0, mem_rd_data[VBIT-1:PAGE_SHIFT], offset_q};
              rsp_fault <= 1'b0;
            end else begin
              rsp_addr  <= '0;
              rsp_fault <= 1'b1;
            end
          end
        end
        default: state <= WK_IDLE;
      endcase
    end
  end

  // R4: the outstanding read holds its address until acknowledged
  p_hold_read_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && !mem_rd_ack) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // R5: an acknowledged read is answered in the following cycle
  p_ack_to_rsp_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && mem_rd_ack) |=> (rsp_valid && !mem_rd_valid));

  // R6: a fault never carries an address
  p_fault_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_addr == '0));

  // R10: responses are single-cycle pulses while a read is pending
  p_no_rsp_in_fetch_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && $past(mem_rd_valid)) |-> !rsp_valid);
endmodule

// File: rtl/iot_translator.sv
module iot_translator
  import iot_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic          reg_half,
  input  logic          reg_hi,
  input  logic [AW-1:0] reg_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_addr,
  output logic          rsp_fault,
  output logic          mem_rd_valid,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_ack,
  input  logic [AW-1:0] mem_rd_data
);
  logic [AW-1:0] base_q, mask_q, dbase_q, entry_addr;
  logic          hit;

  iot_cfg_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .half(reg_half),
    .hi(reg_hi), .wdata(reg_wdata),
    .base_q(base_q), .mask_q(mask_q), .dbase_q(dbase_q)
  );

  iot_window #(.AW(AW)) u_win (
    .addr(req_addr), .base(base_q), .mask(mask_q), .dbase(dbase_q),
    .hit(hit), .entry_addr(entry_addr)
  );

  iot_walker #(.AW(AW)) u_walk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .hit(hit), .entry_addr(entry_addr), .req_ready(req_ready),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault)
  );

  // R1: outputs are quiet right after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!rsp_valid && !mem_rd_valid));

  // R2/R3: a pass-through decision answers next cycle with no read
  p_pass_no_read_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !hit) |=> (rsp_valid && !mem_rd_valid && rsp_addr == $past(req_addr)));

  // R4: an in-window request starts a read and nothing else
  p_hit_fetch_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && hit) |=> (mem_rd_valid && !rsp_valid));

  // R7: no new request is taken while a read is outstanding
  p_one_fetch_r7: assert property (@(posedge clk) disable iff (rst)
    !(req_ready && mem_rd_valid));
endmodule

// File: tb/sim_iot_translator.sv
module sim_iot_translator;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 0, reg_half = 0, reg_hi = 0;
  logic [1:0]  reg_sel = 0;
  logic [63:0] reg_wdata = 0;
  logic        req_valid = 0;
  logic [63:0] req_addr = 0;
  logic        req_ready, rsp_valid, rsp_fault, mem_rd_valid;
  logic [63:0] rsp_addr, mem_rd_addr;
  logic        mem_rd_ack = 0;
  logic [63:0] mem_rd_data = 0;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  localparam logic [63:0] DBASE = 64'h0000_0000_0080_0000;
  localparam logic [63:0] MASK  = 64'hFFFF_FFFF_FFF0_0000;
  localparam logic [63:0] BASE  = 64'h0000_0000_4000_0001;
  localparam logic [63:0] A1    = 64'h0000_0000_4001_2345;
  localparam logic [63:0] A2    = 64'h0000_0001_4001_2345;
  localparam logic [63:0] ENT_OK  = 64'h8000_0012_3456_7ABC;
  localparam logic [63:0] ENT_BAD = 64'h0000_0012_3456_7000;

  always #4 clk = ~clk;

  iot_translator u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_half(reg_half),
    .reg_hi(reg_hi), .reg_wdata(reg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
    .mem_rd_data(mem_rd_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [63:0] ent_addr(input logic [63:0] db, input logic [63:0] a);
    return db + ((a >> 12) * 64'd8);
  endfunction

  function automatic logic [63:0] xl(input logic [63:0] e, input logic [63:0] a);
    return ((e & ~(64'd1 << 63)) & ~64'hFFF) | (a & 64'hFFF);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic half, input logic hi, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1; reg_sel = sel; reg_half = half; reg_hi = hi; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic pass_req(input logic [63:0] a, input string tag);
    @(negedge clk);
    chk({tag, " ready"}, 64'(req_ready), 64'd1);
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " rsp_addr"}, rsp_addr, a);
    chk({tag, " fault"}, 64'(rsp_fault), 64'd0);
    chk({tag, " no read"}, 64'(mem_rd_valid), 64'd0);
    @(negedge clk);
    chk({tag, " R10 pulse"}, 64'(rsp_valid), 64'd0);
  endtask

  task automatic xlat_req(input logic [63:0] a, input logic [63:0] db, input logic [63:0] ent,
                          input int delay, input string tag);
    logic [63:0] ea;
    ea = ent_addr(db, a);
    @(negedge clk);
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " R4 rd_valid"}, 64'(mem_rd_valid), 64'd1);
    chk({tag, " R4 rd_addr"}, mem_rd_addr, ea);
    chk({tag, " R7 ready low"}, 64'(req_ready), 64'd0);
    for (int i = 0; i < delay; i++) begin
      @(negedge clk);
      chk({tag, " R4 hold"}, mem_rd_addr, ea);
      chk({tag, " R4 still valid"}, 64'(mem_rd_valid), 64'd1);
      chk({tag, " R7 no rsp"}, 64'(rsp_valid), 64'd0);
    end
    mem_rd_ack = 1; mem_rd_data = ent;
    @(negedge clk);
    mem_rd_ack = 0;
    chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    if (ent[63]) begin
      chk({tag, " R5 addr"}, rsp_addr, xl(ent, a));
      chk({tag, " R5 fault"}, 64'(rsp_fault), 64'd0);
    end else begin
      chk({tag, " R6 addr"}, rsp_addr, 64'd0);
      chk({tag, " R6 fault"}, 64'(rsp_fault), 64'd1);
    end
    chk({tag, " R7 ready back"}, 64'(req_ready), 64'd1);
    @(negedge clk);
    chk({tag, " R10 pulse"}, 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_reset();
    chk("R1 ready", 64'(req_ready), 64'd1);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 rd_valid", 64'(mem_rd_valid), 64'd0);
    pass_req(A1, "R1 pass");
  endtask

  task automatic t_disabled();
    wr(2'd1, 0, 0, MASK);
    wr(2'd2, 0, 0, DBASE);
    wr(2'd0, 0, 0, BASE & ~64'd1);
    pass_req(A1, "R2 off");
  endtask

  task automatic t_window();
    wr(2'd0, 0, 0, BASE);
    pass_req(64'h0000_0000_5000_0000, "R3 miss");
    xlat_req(A1, DBASE, ENT_OK, 3, "R5 hit");
    xlat_req(A1, DBASE, ENT_BAD, 0, "R6 bad");
  endtask

  task automatic t_half();
    wr(2'd0, 1, 1, 64'h0000_0000_0000_0001);
    pass_req(A1, "R8 hi write");
    xlat_req(A2, DBASE, ENT_OK, 1, "R8 hi match");
    wr(2'd0, 1, 0, 64'h0000_0000_4000_0000);
    pass_req(A2, "R8 lo write");
    wr(2'd0, 1, 0, 64'h0000_0000_4000_0001);
    xlat_req(A2, DBASE, ENT_OK, 0, "R8 hi kept");
    wr(2'd3, 0, 0, 64'd0);
    xlat_req(A2, DBASE, ENT_OK, 0, "R8 sel3");
    wr(2'd0, 0, 0, BASE);
  endtask

  task automatic t_same_cycle();
    logic [63:0] ea;
    ea = ent_addr(DBASE, A1);
    @(negedge clk);
    req_valid = 1; req_addr = A1;
    reg_we = 1; reg_sel = 2'd0; reg_half = 0; reg_wdata = 64'd0;
    @(negedge clk);
    req_valid = 0;
    reg_we = 1; reg_sel = 2'd2; reg_wdata = 64'h0000_0000_0F00_0000;
    chk("R9 old cfg read", 64'(mem_rd_valid), 64'd1);
    chk("R9 old cfg addr", mem_rd_addr, ea);
    @(negedge clk);
    reg_we = 0;
    chk("R9 dbase write no move", mem_rd_addr, ea);
    mem_rd_ack = 1; mem_rd_data = ENT_OK;
    @(negedge clk);
    mem_rd_ack = 0;
    chk("R9 rsp addr", rsp_addr, xl(ENT_OK, A1));
    pass_req(A1, "R9 new cfg");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_window();
    t_half();
    t_same_cycle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule